// File: doc/BRIEF.md
# PCI Bridge Upstream Claim Decoder

This block sits on the upstream side of a PCI-to-PCI bridge and decides, for every transaction whose address phase it sees, what the bridge does with it. The three outcomes are: leave the transaction alone, claim it as a target of the bridge's own configuration space, or claim it and pass it to the downstream bus. The decision uses the command nibble, the 32-bit address, the IDSEL input, three forwarding windows (I/O, prefetch-free memory and memory-mapped I/O) and the secondary and subordinate bus numbers.

For a forwarded configuration cycle the block also reports the form it must take downstream. A Type 1 cycle aimed at the secondary bus becomes Type 0. A Type 1 cycle aimed at a deeper bus goes out unchanged. A special-cycle request goes out as a special cycle. The result is registered and appears one clock after the address phase is marked valid. The bus timing machine, data buffers and register file are outside this block and supply its window and bus-number inputs.

Top module: `pcib_claim_decode`

## Requirements
- R1: The outputs are registered. `dec_valid` is high exactly in the cycle after a cycle with `addr_valid` high. In any cycle where `dec_valid` is low, all decision outputs are low. Synchronous reset clears every output.
- R2: Commands 4'b0000 (interrupt acknowledge) and 4'b0001 (special cycle) are never claimed and never forwarded.
- R3: Commands 4'b0100, 4'b0101, 4'b1000 and 4'b1001 are reserved and are ignored. Encodings 4'b1100 to 4'b1111 are not decoded and are ignored as well.
- R4: Commands 4'b0010 (I/O read) and 4'b0011 (I/O write) are claimed and forwarded when the address is inside the I/O window. Otherwise they are neither claimed nor forwarded.
- R5: Commands 4'b0110 (memory read) and 4'b0111 (memory write) are claimed and forwarded when the address is inside the memory window or inside the memory-mapped I/O window. Otherwise they are ignored.
- R6: A window hit means base <= address <= limit, with both bounds included. A window whose limit is below its base matches no address.
- R7: Configuration commands 4'b1010 (read) and 4'b1011 (write) with address bits [1:0] = 2'b00 (Type 0) are claimed for internal access only when `idsel` is high and the function number in address bits [10:8] has its bit set in `func_present`. Such a cycle is never forwarded.
- R8: A Type 1 configuration cycle (address bits [1:0] = 2'b01) whose target bus in address bits [23:16] equals `sec_bus` is claimed and forwarded with `to_type0` high.
- R9: A Type 1 configuration cycle whose target bus is greater than `sec_bus` and no greater than `sub_bus` is claimed and forwarded with `to_type0` low. Any other target bus is ignored.
- R10: A Type 1 configuration write with device field [15:11] = 5'h1F, function field [10:8] = 3'h7 and register field [7:2] = 0 is a special-cycle request. It is forwarded with `special` high and `to_type0` low only when its target bus equals `sec_bus`, and is ignored otherwise. A configuration read with the same fields follows R8 and R9.
- R11: `claim` is high exactly when `forward` or `internal` is high, and `forward` and `internal` are never high together.
- R12: A configuration cycle with address bits [1:0] equal to 2'b10 or 2'b11 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_valid | input | 1 | Marks the address phase of a transaction |
| cmd | input | 4 | Bus command nibble |
| ad | input | 32 | Address during the address phase |
| idsel | input | 1 | Configuration select for this bridge |
| func_present | input | 8 | One bit per implemented function number |
| io_base | input | 32 | I/O forwarding window, lowest address |
| io_limit | input | 32 | I/O forwarding window, highest address |
| mem_base | input | 32 | Memory forwarding window, lowest address |
| mem_limit | input | 32 | Memory forwarding window, highest address |
| mmio_base | input | 32 | Memory-mapped I/O window, lowest address |
| mmio_limit | input | 32 | Memory-mapped I/O window, highest address |
| sec_bus | input | 8 | Secondary bus number |
| sub_bus | input | 8 | Subordinate bus number |
| dec_valid | output | 1 | Decision outputs are valid this cycle |
| claim | output | 1 | Bridge claims the transaction |
| forward | output | 1 | Transaction is passed downstream |
| to_type0 | output | 1 | Forwarded configuration cycle becomes Type 0 |
| internal | output | 1 | Transaction targets the bridge's own configuration space |
| special | output | 1 | Forwarded configuration write becomes a special cycle |

## Verification
Each command class is tried with addresses on both bounds of each window and one step outside them. This separates inclusive compares from exclusive ones, and shows whether memory cycles fall through to the I/O window or I/O cycles fall through to a memory window. Configuration cycles are tried with target buses one below, equal to, inside and one above the secondary/subordinate range. The same field patterns are used as reads and as writes, which separates Type 0 conversion, unchanged Type 1 forwarding and special-cycle handling. Further cases cover an inverted window, IDSEL with absent functions, back-to-back address phases and idle cycles, which check disabling, the function mask and the one-cycle registration.

// File: rtl/pcib_claim_pkg.sv
`timescale 1ns/1ps
package pcib_claim_pkg;

    localparam int ADDR_W = 32;
    localparam int BUS_W  = 8;
    localparam int NFUNC  = 8;
    localparam int FN_W   = $clog2(NFUNC);
    localparam int NWIN   = 3;

    localparam int WIN_IO   = 0;
    localparam int WIN_MEM  = 1;
    localparam int WIN_MMIO = 2;

    localparam logic [3:0] CMD_INTA  = 4'b0000;
    localparam logic [3:0] CMD_SPEC  = 4'b0001;
    localparam logic [3:0] CMD_IORD  = 4'b0010;
    localparam logic [3:0] CMD_IOWR  = 4'b0011;
    localparam logic [3:0] CMD_MEMRD = 4'b0110;
    localparam logic [3:0] CMD_MEMWR = 4'b0111;
    localparam logic [3:0] CMD_CFGRD = 4'b1010;
    localparam logic [3:0] CMD_CFGWR = 4'b1011;

    // Outcome of one address-phase decode
    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_LOCAL,
        ACT_PASS,
        ACT_PASS_T0,
        ACT_PASS_SPC
    } action_e;

    typedef struct packed {
        logic    vld;
        action_e act;
    } dec_t;

    // Type 1 write aimed at device 31, function 7, register 0
    function automatic logic is_spc_req(input logic [23:0] a);
        return (a[1:0] == 2'b01) && (a[15:11] == 5'h1F) &&
               (a[10:8] == 3'h7) && (a[7:2] == 6'h00);
    endfunction

    function automatic logic is_pass(input action_e a);
        return (a == ACT_PASS) || (a == ACT_PASS_T0) || (a == ACT_PASS_SPC);
    endfunction

endpackage

// File: rtl/pcib_win_cmp.sv
`timescale 1ns/1ps
module pcib_win_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] addr,
    input  logic [W-1:0] base,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic enabled;

    always_comb begin
        enabled = (limit >= base);
        hit     = enabled && (addr >= base) && (addr <= limit);
    end
endmodule

// File: rtl/pcib_cfg_dec.sv
`timescale 1ns/1ps
module pcib_cfg_dec
    import pcib_claim_pkg::*;
(
    input  logic             is_wr,
    input  logic [23:0]      a,
    input  logic             idsel,
    input  logic [NFUNC-1:0] func_present,
    input  logic [BUS_W-1:0] sec_bus,
    input  logic [BUS_W-1:0] sub_bus,
    output action_e          act
);
    logic [BUS_W-1:0] tbus;
    logic [FN_W-1:0]  fn;
    logic             behind;

    always_comb begin
        tbus   = a[16 +: BUS_W];
        fn     = a[8 +: FN_W];
        behind = (tbus > sec_bus) && (tbus <= sub_bus);
        act    = ACT_NONE;
        unique case (a[1:0])
            2'b00: if (idsel && func_present[fn]) act = ACT_LOCAL;
            2'b01: begin
                if (is_wr && is_spc_req(a)) begin
                    if (tbus == sec_bus) act = ACT_PASS_SPC;
                end else if (tbus == sec_bus) begin
                    act = ACT_PASS_T0;
                end else if (behind) begin
                    act = ACT_PASS;
                end
            end
            default: act = ACT_NONE;
        endcase
    end
endmodule

// File: rtl/pcib_claim_decode.sv
`timescale 1ns/1ps
module pcib_claim_decode
    import pcib_claim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_valid,
    input  logic [3:0]        cmd,
    input  logic [ADDR_W-1:0] ad,
    input  logic              idsel,
    input  logic [NFUNC-1:0]  func_present,
    input  logic [ADDR_W-1:0] io_base,
    input  logic [ADDR_W-1:0] io_limit,
    input  logic [ADDR_W-1:0] mem_base,
    input  logic [ADDR_W-1:0] mem_limit,
    input  logic [ADDR_W-1:0] mmio_base,
    input  logic [ADDR_W-1:0] mmio_limit,
    input  logic [BUS_W-1:0]  sec_bus,
    input  logic [BUS_W-1:0]  sub_bus,
    output logic              dec_valid,
    output logic              claim,
    output logic              forward,
    output logic              to_type0,
    output logic              internal,
    output logic              special
);
    logic [NWIN-1:0][ADDR_W-1:0] wbase;
    logic [NWIN-1:0][ADDR_W-1:0] wlim;
    logic [NWIN-1:0]             whit;
    action_e                     cfg_act;
    action_e                     act_d;
    dec_t                        dec_q;

    always_comb begin
        wbase[WIN_IO]   = io_base;
        wlim[WIN_IO]    = io_limit;
        wbase[WIN_MEM]  = mem_base;
        wlim[WIN_MEM]   = mem_limit;
        wbase[WIN_MMIO] = mmio_base;
        wlim[WIN_MMIO]  = mmio_limit;
    end

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        pcib_win_cmp #(.W(ADDR_W)) u_win (
            .addr  (ad),
            .base  (wbase[g]),
            .limit (wlim[g]),
            .hit   (whit[g])
        );
    end

    pcib_cfg_dec u_cfg (
        .is_wr        (cmd == CMD_CFGWR),
        .a            (ad[23:0]),
        .idsel        (idsel),
        .func_present (func_present),
        .sec_bus      (sec_bus),
        .sub_bus      (sub_bus),
        .act          (cfg_act)
    );

    always_comb begin
        act_d = ACT_NONE;
        case (cmd)
            CMD_IORD, CMD_IOWR:
                if (whit[WIN_IO]) act_d = ACT_PASS;
            CMD_MEMRD, CMD_MEMWR:
                if (whit[WIN_MEM] || whit[WIN_MMIO]) act_d = ACT_PASS;
            CMD_CFGRD, CMD_CFGWR:
                act_d = cfg_act;
            default:
                act_d = ACT_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !addr_valid) begin
            dec_q.vld <= rst ? 1'b0 : 1'b0;
            dec_q.act <= ACT_NONE;
        end else begin
            dec_q.vld <= 1'b1;
            dec_q.act <= act_d;
        end
    end

    always_comb begin
        dec_valid = dec_q.vld;
        forward   = is_pass(dec_q.act);
        internal  = (dec_q.act == ACT_LOCAL);
        to_type0  = (dec_q.act == ACT_PASS_T0);
        special   = (dec_q.act == ACT_PASS_SPC);
        claim     = (dec_q.act != ACT_NONE);
    end
endmodule

// File: rtl/pcib_claim_chk.sv
`timescale 1ns/1ps
module pcib_claim_chk (
    input logic       clk,
    input logic       rst,
    input logic       addr_valid,
    input logic [3:0] cmd,
    input logic [1:0] ad_lo,
    input logic       dec_valid,
    input logic       claim,
    input logic       forward,
    input logic       to_type0,
    input logic       internal,
    input logic       special
);
    assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
        addr_valid |=> dec_valid);
    assert_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !addr_valid |=> !dec_valid && !claim && !forward && !internal);
    assert_never_R2: assert property (@(posedge clk) disable iff (rst)
        addr_valid && (cmd == 4'b0000 || cmd == 4'b0001) |=> !claim);
    assert_reserved_R3: assert property (@(posedge clk) disable iff (rst)
        addr_valid && (cmd == 4'b0100 || cmd == 4'b0101 ||
                       cmd == 4'b1000 || cmd == 4'b1001) |=> !claim);
    assert_type0_local_R7: assert property (@(posedge clk) disable iff (rst)
        addr_valid && (cmd == 4'b1010 || cmd == 4'b1011) && ad_lo == 2'b00
        |=> !forward);
    assert_conv_R8: assert property (@(posedge clk) disable iff (rst)
        to_type0 |-> forward && !special);
    assert_spc_R10: assert property (@(posedge clk) disable iff (rst)
        special |-> forward && !to_type0);
    assert_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(forward && internal) && (claim == (forward || internal)));
    assert_badtype_R12: assert property (@(posedge clk) disable iff (rst)
        addr_valid && (cmd == 4'b1010 || cmd == 4'b1011) && ad_lo[1]
        |=> !claim);
endmodule

bind pcib_claim_decode pcib_claim_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr_valid (addr_valid),
    .cmd        (cmd),
    .ad_lo      (ad[1:0]),
    .dec_valid  (dec_valid),
    .claim      (claim),
    .forward    (forward),
    .to_type0   (to_type0),
    .internal   (internal),
    .special    (special)
);

// File: tb/pcib_claim_decode_tb.sv
`timescale 1ns/1ps
module pcib_claim_decode_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_valid = 1'b0;
    logic [3:0]  cmd = 4'h0;
    logic [31:0] ad = 32'h0;
    logic        idsel = 1'b0;
    logic [7:0]  func_present = 8'b0000_0011;
    logic [31:0] io_base = 32'h0000_1000, io_limit = 32'h0000_1FFF;
    logic [31:0] mem_base = 32'h8000_0000, mem_limit = 32'h8FFF_FFFF;
    logic [31:0] mmio_base = 32'hA000_0000, mmio_limit = 32'hA00F_FFFF;
    logic [7:0]  sec_bus = 8'd5, sub_bus = 8'd9;
    logic dec_valid, claim, forward, to_type0, internal, special;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pcib_claim_decode u_dut (
        .clk(clk), .rst(rst), .addr_valid(addr_valid), .cmd(cmd), .ad(ad),
        .idsel(idsel), .func_present(func_present),
        .io_base(io_base), .io_limit(io_limit),
        .mem_base(mem_base), .mem_limit(mem_limit),
        .mmio_base(mmio_base), .mmio_limit(mmio_limit),
        .sec_bus(sec_bus), .sub_bus(sub_bus),
        .dec_valid(dec_valid), .claim(claim), .forward(forward),
        .to_type0(to_type0), .internal(internal), .special(special)
    );

    // {req, cmd, ad, idsel, expected {claim, forward, to_type0, internal, special}}
    localparam int NV = 30;
    localparam logic [45:0] VEC [NV] = '{
        {4'd2,  4'h0, 32'h0000_1000, 1'b0, 5'b00000}, // R2 interrupt ack
        {4'd2,  4'h1, 32'h8000_0000, 1'b0, 5'b00000}, // R2 special cycle
        {4'd4,  4'h2, 32'h0000_1000, 1'b0, 5'b11000}, // R4 R6 io base
        {4'd4,  4'h3, 32'h0000_1FFF, 1'b0, 5'b11000}, // R4 R6 io limit
        {4'd4,  4'h2, 32'h0000_2000, 1'b0, 5'b00000}, // R4 above
        {4'd4,  4'h3, 32'h0000_0FFF, 1'b0, 5'b00000}, // R4 below
        {4'd4,  4'h2, 32'h8000_0000, 1'b0, 5'b00000}, // R4 mem addr on io cmd
        {4'd5,  4'h6, 32'h8000_0000, 1'b0, 5'b11000}, // R5 R6 mem base
        {4'd5,  4'h7, 32'h8FFF_FFFF, 1'b0, 5'b11000}, // R5 mem limit
        {4'd5,  4'h6, 32'hA00F_FFFF, 1'b0, 5'b11000}, // R5 mmio limit
        {4'd5,  4'h7, 32'h9000_0000, 1'b0, 5'b00000}, // R5 gap
        {4'd5,  4'h6, 32'h0000_1000, 1'b0, 5'b00000}, // R5 io addr on mem cmd
        {4'd5,  4'h7, 32'hA010_0000, 1'b0, 5'b00000}, // R5 above mmio
        {4'd3,  4'h4, 32'h0000_1000, 1'b0, 5'b00000}, // R3
        {4'd3,  4'h5, 32'h0000_1000, 1'b0, 5'b00000}, // R3
        {4'd3,  4'h8, 32'h8000_0000, 1'b0, 5'b00000}, // R3
        {4'd3,  4'h9, 32'h8000_0000, 1'b0, 5'b00000}, // R3
        {4'd3,  4'hC, 32'h8000_0000, 1'b0, 5'b00000}, // R3 undecoded
        {4'd7,  4'hA, 32'h0000_0100, 1'b1, 5'b10010}, // R7 fn1 present
        {4'd7,  4'hB, 32'h0000_0000, 1'b1, 5'b10010}, // R7 write fn0
        {4'd7,  4'hA, 32'h0000_0200, 1'b1, 5'b00000}, // R7 fn2 absent
        {4'd7,  4'hA, 32'h0000_0100, 1'b0, 5'b00000}, // R7 no idsel
        {4'd8,  4'hA, 32'h0005_0001, 1'b0, 5'b11100}, // R8 bus == sec
        {4'd9,  4'hB, 32'h0009_0001, 1'b0, 5'b11000}, // R9 bus == sub
        {4'd9,  4'hA, 32'h000A_0001, 1'b0, 5'b00000}, // R9 above sub
        {4'd9,  4'hA, 32'h0004_0001, 1'b0, 5'b00000}, // R9 below sec
        {4'd10, 4'hB, 32'h0005_FF01, 1'b0, 5'b11001}, // R10 special to sec
        {4'd10, 4'hB, 32'h0006_FF01, 1'b0, 5'b00000}, // R10 special deeper
        {4'd10, 4'hA, 32'h0005_FF01, 1'b0, 5'b11100}, // R10 read same fields
        {4'd12, 4'hA, 32'h0005_0002, 1'b0, 5'b00000}  // R12 type field 10
    };

    task automatic check(input string req, input logic ev, input logic [4:0] exp);
        logic [4:0] got;
        got = {claim, forward, to_type0, internal, special};
        checks++;
        if (dec_valid !== ev || got !== exp) begin
            errors++;
            $display("FAIL %s actual valid=%b out=%b expected valid=%b out=%b",
                     req, dec_valid, got, ev, exp);
        end
        checks++;
        if ((forward && internal) || (claim !== (forward | internal))) begin
            errors++;
            $display("FAIL R11 actual claim=%b fwd=%b int=%b expected exclusive",
                     claim, forward, internal);
        end
    endtask

    task automatic run(input string req, input logic [3:0] c, input logic [31:0] a,
                       input logic sel, input logic [4:0] exp);
        @(negedge clk);
        addr_valid = 1'b1; cmd = c; ad = a; idsel = sel;
        @(negedge clk);
        addr_valid = 1'b0;
        check(req, 1'b1, exp);
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL R1 actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset: valid held high during reset, outputs stay clear
        addr_valid = 1'b1; cmd = 4'h2; ad = 32'h0000_1000;
        repeat (3) @(negedge clk);
        check("R1 reset", 1'b0, 5'b00000);
        addr_valid = 1'b0;
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            run($sformatf("R%0d vec%0d", VEC[i][45:42], i),
                VEC[i][41:38], VEC[i][37:6], VEC[i][5], VEC[i][4:0]);
        end
        run("R12 type field 11", 4'hB, 32'h0005_0003, 1'b0, 5'b00000);

        // R1 idle: a hitting command without valid yields nothing
        @(negedge clk); cmd = 4'h2; ad = 32'h0000_1800;
        @(negedge clk);
        check("R1 idle", 1'b0, 5'b00000);

        // R1 back-to-back address phases
        @(negedge clk); addr_valid = 1'b1; cmd = 4'h6; ad = 32'h8000_0004;
        @(negedge clk);
        check("R1 b2b first", 1'b1, 5'b11000);
        cmd = 4'hA; ad = 32'h0007_0001;
        @(negedge clk); addr_valid = 1'b0;
        check("R1 b2b second", 1'b1, 5'b11000);

        // R6 inverted io window matches nothing, even its bounds
        io_base = 32'h0000_2000; io_limit = 32'h0000_1000;
        run("R6 disabled mid", 4'h2, 32'h0000_1800, 1'b0, 5'b00000);
        run("R6 disabled base", 4'h2, 32'h0000_2000, 1'b0, 5'b00000);
        run("R6 disabled limit", 4'h3, 32'h0000_1000, 1'b0, 5'b00000);

        // R6 single-address window
        io_base = 32'h0000_3000; io_limit = 32'h0000_3000;
        run("R6 single hit", 4'h2, 32'h0000_3000, 1'b0, 5'b11000);

        // R9 sec == sub: nothing lies behind beyond the secondary
        sub_bus = 8'd5;
        run("R9 empty range", 4'hA, 32'h0006_0001, 1'b0, 5'b00000);
        run("R8 sec only", 4'hA, 32'h0005_0001, 1'b0, 5'b11100);

        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule